// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Integer Pipeline

This block sits beside the execute stage of an in-order integer pipeline whose stages are fetch, decode with register read, execute, memory and writeback. A result is written into the register file only at writeback, but the consumer reads it at decode. Without a bypass, a dependent instruction that follows right behind its producer would lose two cycles. The selector compares the two source register numbers of the instruction now in execute with the destination numbers of the two older instructions still in flight. These are held in the execute/memory latch and the memory/writeback latch. For each ALU operand it picks either the value read from the register file or one of the two latched results.

Only read-after-write dependences need this treatment. With in-order issue and register reads in decode, a write can never overtake an earlier read. When both older instructions target the same register, the younger value from the execute/memory latch wins. Register zero never takes part in a bypass, and neither does a producer whose write enable is low. The third instruction after a producer gets its value from the register file. The file writes early in the cycle, and a small write-through path on the decode read ports models this, so a value being written back is seen by a same-cycle decode read.

A parameter can add one register stage on all outputs, for pipelines that want the selects latched before the ALU input multiplexer.

Top module: `fwd_unit`

## Requirements
- R1: When neither older instruction writes a source register of the execute instruction, that operand's select is 2'b00 and its value is the register file value latched for it.
- R2: When the execute/memory instruction writes (enable high) a nonzero register equal to a source, that operand's select is 2'b01 and its value is the execute/memory result.
- R3: When only the memory/writeback instruction writes (enable high) a nonzero register equal to a source, that operand's select is 2'b10 and its value is the memory/writeback result.
- R4: When both older instructions write the same nonzero source register, the select is 2'b01 and the execute/memory result is used (youngest producer wins).
- R5: A producer whose write enable is low is ignored, whatever its destination number is.
- R6: A producer whose destination is register 0 is never forwarded, even with its enable high.
- R7: The two operands are steered independently; each may take a different path in the same cycle.
- R8: A decode-stage read of a nonzero register that the writeback instruction writes in the same cycle returns the writeback result; otherwise it returns the raw register file read data.
- R9: The select code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the optional output register) |
| rst_n | input | 1 | Active-low reset |
| ex_src_a | input | RIDX | First source register number of the execute instruction |
| ex_src_b | input | RIDX | Second source register number of the execute instruction |
| ex_rf_a | input | XLEN | Register file value latched for the first source |
| ex_rf_b | input | XLEN | Register file value latched for the second source |
| em_dst | input | RIDX | Destination of the execute/memory instruction |
| em_wen | input | 1 | Write enable of the execute/memory instruction |
| em_val | input | XLEN | Result held in the execute/memory latch |
| mw_dst | input | RIDX | Destination of the memory/writeback instruction |
| mw_wen | input | 1 | Write enable of the memory/writeback instruction |
| mw_val | input | XLEN | Result held in the memory/writeback latch |
| id_src_a | input | RIDX | First source register number being read in decode |
| id_src_b | input | RIDX | Second source register number being read in decode |
| id_raw_a | input | XLEN | Raw register file read data for the first decode source |
| id_raw_b | input | XLEN | Raw register file read data for the second decode source |
| sel_a | output | 2 | Path chosen for the first ALU operand |
| sel_b | output | 2 | Path chosen for the second ALU operand |
| opnd_a | output | XLEN | First ALU operand value |
| opnd_b | output | XLEN | Second ALU operand value |
| id_rd_a | output | XLEN | First decode read value after write-through |
| id_rd_b | output | XLEN | Second decode read value after write-through |

## Verification
The bench first applies patterns with no overlap between sources and destinations. It then matches a single producer on one operand at a time, which shows whether each latch is wired to the right select code and data path. Patterns where both producers target the same register tell a correct youngest-first priority apart from a reversed one. Patterns with enable low, or with a destination of register 0, show whether the qualifiers are really applied. Split patterns, where each operand matches a different producer, expose crossed operand wiring. A sweep over every register number, with both producers set to different destinations, confirms that a match on any index and on either operand gives the right select and never the unused code.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // Operand path select codes; the ALU input mux decodes these values.
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_EM  = 2'b01,
      SEL_MW  = 2'b10,
      SEL_BAD = 2'b11
   } fwd_sel_e;

   // Producer slots, youngest first; the slot order is the priority order.
   localparam int unsigned NPROD   = 2;
   localparam int unsigned PROD_EM = 0;
   localparam int unsigned PROD_MW = 1;

   function automatic fwd_sel_e slot_to_sel(input int unsigned slot);
      fwd_sel_e s;
      case (slot)
         PROD_EM: s = SEL_EM;
         PROD_MW: s = SEL_MW;
         default: s = SEL_RF;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/fwd_match.sv
// Decides whether one producer supplies one consumer source.
module fwd_match #(
   parameter int unsigned RIDX      = 5,
   parameter bit          ZERO_LOCK = 1'b1
) (
   input  logic [RIDX-1:0] src,
   input  logic [RIDX-1:0] dst,
   input  logic            wen,
   output logic            hit
);

   logic same;
   logic dst_live;

   assign same = (src == dst);

   generate
      if (ZERO_LOCK) begin : g_lock
         assign dst_live = |dst;
      end else begin : g_nolock
         assign dst_live = 1'b1;
      end
   endgenerate

   assign hit = wen & same & dst_live;

endmodule

// File: rtl/fwd_operand.sv
// Steers one ALU operand among the register file and all producer slots.
module fwd_operand
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned RIDX      = 5,
   parameter bit          ZERO_LOCK = 1'b1
) (
   input  logic [RIDX-1:0]            src,
   input  logic [XLEN-1:0]            rf_val,
   input  logic [NPROD-1:0][RIDX-1:0] p_dst,
   input  logic [NPROD-1:0]           p_wen,
   input  logic [NPROD-1:0][XLEN-1:0] p_val,
   output fwd_sel_e                   sel,
   output logic [XLEN-1:0]            val
);

   logic [NPROD-1:0] hit;

   genvar gp;
   generate
      for (gp = 0; gp < NPROD; gp++) begin : g_prod
         fwd_match #(
            .RIDX      (RIDX),
            .ZERO_LOCK (ZERO_LOCK)
         ) u_match (
            .src (src),
            .dst (p_dst[gp]),
            .wen (p_wen[gp]),
            .hit (hit[gp])
         );
      end
   endgenerate

   // Scan from oldest to youngest so that the youngest hit is kept last.
   always_comb begin
      sel = SEL_RF;
      val = rf_val;
      for (int k = NPROD - 1; k >= 0; k--) begin
         if (hit[k]) begin
            sel = slot_to_sel(k);
            val = p_val[k];
         end
      end
   end

endmodule

// File: rtl/fwd_dec_bypass.sv
// Write-through on a decode read port: the writeback value is visible in the same cycle.
module fwd_dec_bypass #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned RIDX      = 5,
   parameter bit          ZERO_LOCK = 1'b1
) (
   input  logic [RIDX-1:0] src,
   input  logic [XLEN-1:0] raw,
   input  logic [RIDX-1:0] wb_dst,
   input  logic            wb_wen,
   input  logic [XLEN-1:0] wb_val,
   output logic [XLEN-1:0] rd
);

   logic hit;

   fwd_match #(
      .RIDX      (RIDX),
      .ZERO_LOCK (ZERO_LOCK)
   ) u_match (
      .src (src),
      .dst (wb_dst),
      .wen (wb_wen),
      .hit (hit)
   );

   assign rd = hit ? wb_val : raw;

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned NREG      = 32,
   parameter bit          ZERO_LOCK = 1'b1,
   parameter bit          REG_OUT   = 1'b0,
   localparam int unsigned RIDX     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RIDX-1:0] ex_src_a,
   input  logic [RIDX-1:0] ex_src_b,
   input  logic [XLEN-1:0] ex_rf_a,
   input  logic [XLEN-1:0] ex_rf_b,
   input  logic [RIDX-1:0] em_dst,
   input  logic            em_wen,
   input  logic [XLEN-1:0] em_val,
   input  logic [RIDX-1:0] mw_dst,
   input  logic            mw_wen,
   input  logic [XLEN-1:0] mw_val,
   input  logic [RIDX-1:0] id_src_a,
   input  logic [RIDX-1:0] id_src_b,
   input  logic [XLEN-1:0] id_raw_a,
   input  logic [XLEN-1:0] id_raw_b,
   output logic [1:0]      sel_a,
   output logic [1:0]      sel_b,
   output logic [XLEN-1:0] opnd_a,
   output logic [XLEN-1:0] opnd_b,
   output logic [XLEN-1:0] id_rd_a,
   output logic [XLEN-1:0] id_rd_b
);

   localparam int unsigned NOPND = 2;

   generate
      if (XLEN < 1) begin : g_bad_xlen
         $error("fwd_unit: XLEN must be at least 1");
      end
      if (NREG < 2) begin : g_bad_nreg
         $error("fwd_unit: NREG must be at least 2");
      end
   endgenerate

   // Gather the producers into slot arrays in priority order.
   logic [NPROD-1:0][RIDX-1:0] p_dst;
   logic [NPROD-1:0]           p_wen;
   logic [NPROD-1:0][XLEN-1:0] p_val;

   always_comb begin
      p_dst[PROD_EM] = em_dst;
      p_wen[PROD_EM] = em_wen;
      p_val[PROD_EM] = em_val;
      p_dst[PROD_MW] = mw_dst;
      p_wen[PROD_MW] = mw_wen;
      p_val[PROD_MW] = mw_val;
   end

   logic [NOPND-1:0][RIDX-1:0] c_src;
   logic [NOPND-1:0][XLEN-1:0] c_rf;
   logic [NOPND-1:0][RIDX-1:0] d_src;
   logic [NOPND-1:0][XLEN-1:0] d_raw;
   fwd_sel_e                   n_sel [NOPND];
   logic [NOPND-1:0][XLEN-1:0] n_val;
   logic [NOPND-1:0][XLEN-1:0] n_dec;

   assign c_src[0] = ex_src_a;
   assign c_src[1] = ex_src_b;
   assign c_rf[0]  = ex_rf_a;
   assign c_rf[1]  = ex_rf_b;
   assign d_src[0] = id_src_a;
   assign d_src[1] = id_src_b;
   assign d_raw[0] = id_raw_a;
   assign d_raw[1] = id_raw_b;

   genvar go;
   generate
      for (go = 0; go < NOPND; go++) begin : g_opnd
         fwd_operand #(
            .XLEN      (XLEN),
            .RIDX      (RIDX),
            .ZERO_LOCK (ZERO_LOCK)
         ) u_opnd (
            .src    (c_src[go]),
            .rf_val (c_rf[go]),
            .p_dst  (p_dst),
            .p_wen  (p_wen),
            .p_val  (p_val),
            .sel    (n_sel[go]),
            .val    (n_val[go])
         );

         fwd_dec_bypass #(
            .XLEN      (XLEN),
            .RIDX      (RIDX),
            .ZERO_LOCK (ZERO_LOCK)
         ) u_dec (
            .src    (d_src[go]),
            .raw    (d_raw[go]),
            .wb_dst (mw_dst),
            .wb_wen (mw_wen),
            .wb_val (mw_val),
            .rd     (n_dec[go])
         );
      end
   endgenerate

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_a   <= 2'b00;
               sel_b   <= 2'b00;
               opnd_a  <= '0;
               opnd_b  <= '0;
               id_rd_a <= '0;
               id_rd_b <= '0;
            end else begin
               sel_a   <= n_sel[0];
               sel_b   <= n_sel[1];
               opnd_a  <= n_val[0];
               opnd_b  <= n_val[1];
               id_rd_a <= n_dec[0];
               id_rd_b <= n_dec[1];
            end
         end
      end else begin : g_comb
         assign sel_a   = n_sel[0];
         assign sel_b   = n_sel[1];
         assign opnd_a  = n_val[0];
         assign opnd_b  = n_val[1];
         assign id_rd_a = n_dec[0];
         assign id_rd_b = n_dec[1];
      end
   endgenerate

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned RIDX    = 5,
   parameter bit          REG_OUT = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [RIDX-1:0] ex_src_a,
   input logic [RIDX-1:0] ex_src_b,
   input logic [XLEN-1:0] ex_rf_a,
   input logic [XLEN-1:0] ex_rf_b,
   input logic [RIDX-1:0] em_dst,
   input logic            em_wen,
   input logic [XLEN-1:0] em_val,
   input logic [RIDX-1:0] mw_dst,
   input logic            mw_wen,
   input logic [XLEN-1:0] mw_val,
   input logic [RIDX-1:0] id_src_a,
   input logic [XLEN-1:0] id_raw_a,
   input logic [1:0]      sel_a,
   input logic [1:0]      sel_b,
   input logic [XLEN-1:0] opnd_a,
   input logic [XLEN-1:0] opnd_b,
   input logic [XLEN-1:0] id_rd_a
);

   logic em_a, mw_a, em_b, mw_b, wb_id;
   assign em_a  = em_wen && (em_dst != '0) && (em_dst == ex_src_a);
   assign mw_a  = mw_wen && (mw_dst != '0) && (mw_dst == ex_src_a);
   assign em_b  = em_wen && (em_dst != '0) && (em_dst == ex_src_b);
   assign mw_b  = mw_wen && (mw_dst != '0) && (mw_dst == ex_src_b);
   assign wb_id = mw_wen && (mw_dst != '0) && (mw_dst == id_src_a);

   // R9
   legal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a != 2'b11) && (sel_b != 2'b11));

   generate
      if (!REG_OUT) begin : g_comb
         // R1
         rf_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!em_a && !mw_a) |-> (sel_a == 2'b00 && opnd_a == ex_rf_a));
         // R2 R4
         em_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            em_b |-> (sel_b == 2'b01 && opnd_b == em_val));
         // R3
         mw_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mw_a && !em_a) |-> (sel_a == 2'b10 && opnd_a == mw_val));
         // R6
         zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_src_b == '0) |-> (sel_b == 2'b00));
         // R8
         dec_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wb_id |-> (id_rd_a == mw_val));
      end else begin : g_reg
         // R1
         rf_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!em_a && !mw_a) |=> (sel_a == 2'b00 && opnd_a == $past(ex_rf_a)));
         // R2 R4
         em_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            em_b |=> (sel_b == 2'b01 && opnd_b == $past(em_val)));
         // R8
         dec_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wb_id) |=> (id_rd_a == $past(id_raw_a)));
      end
   endgenerate

endmodule

bind fwd_unit fwd_unit_chk #(
   .XLEN    (XLEN),
   .RIDX    (RIDX),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ex_src_a (ex_src_a),
   .ex_src_b (ex_src_b),
   .ex_rf_a  (ex_rf_a),
   .ex_rf_b  (ex_rf_b),
   .em_dst   (em_dst),
   .em_wen   (em_wen),
   .em_val   (em_val),
   .mw_dst   (mw_dst),
   .mw_wen   (mw_wen),
   .mw_val   (mw_val),
   .id_src_a (id_src_a),
   .id_raw_a (id_raw_a),
   .sel_a    (sel_a),
   .sel_b    (sel_b),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .id_rd_a  (id_rd_a)
);

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;

   localparam int XLEN = 32;
   localparam int RIDX = 5;
   localparam logic [XLEN-1:0] RFA = 32'hA0A0_0001;
   localparam logic [XLEN-1:0] RFB = 32'hB0B0_0002;
   localparam logic [XLEN-1:0] EMV = 32'hE3E3_0003;
   localparam logic [XLEN-1:0] MWV = 32'hD4D4_0004;
   localparam logic [XLEN-1:0] IRA = 32'h1D1D_0005;
   localparam logic [XLEN-1:0] IRB = 32'h2D2D_0006;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [RIDX-1:0] ex_src_a, ex_src_b, em_dst, mw_dst, id_src_a, id_src_b;
   logic [XLEN-1:0] ex_rf_a, ex_rf_b, em_val, mw_val, id_raw_a, id_raw_b;
   logic            em_wen, mw_wen;
   logic [1:0]      sel_a, sel_b;
   logic [XLEN-1:0] opnd_a, opnd_b, id_rd_a, id_rd_b;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   fwd_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
      .em_dst(em_dst), .em_wen(em_wen), .em_val(em_val),
      .mw_dst(mw_dst), .mw_wen(mw_wen), .mw_val(mw_val),
      .id_src_a(id_src_a), .id_src_b(id_src_b), .id_raw_a(id_raw_a), .id_raw_b(id_raw_b),
      .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .id_rd_a(id_rd_a), .id_rd_b(id_rd_b)
   );

   task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Inputs change just after the falling edge; outputs are read a little later.
   task automatic apply(input logic [RIDX-1:0] sa, input logic [RIDX-1:0] sb,
                        input logic [RIDX-1:0] ed, input logic ew,
                        input logic [RIDX-1:0] md, input logic mw);
      @(negedge clk);
      ex_src_a = sa; ex_src_b = sb;
      em_dst = ed; em_wen = ew;
      mw_dst = md; mw_wen = mw;
      #2;
   endtask

   task automatic t_reset;
      chk("R1 reset sel_a", {30'd0, sel_a}, 32'd0);
      chk("R1 reset opnd_a", opnd_a, RFA);
      chk("R1 reset sel_b", {30'd0, sel_b}, 32'd0);
   endtask

   task automatic t_no_match;
      apply(5'd3, 5'd4, 5'd7, 1'b1, 5'd9, 1'b1);
      chk("R1 sel_a", {30'd0, sel_a}, 32'd0);
      chk("R1 opnd_a", opnd_a, RFA);
      chk("R1 opnd_b", opnd_b, RFB);
   endtask

   task automatic t_em;
      apply(5'd6, 5'd2, 5'd6, 1'b1, 5'd9, 1'b1);
      chk("R2 sel_a", {30'd0, sel_a}, 32'd1);
      chk("R2 opnd_a", opnd_a, EMV);
      chk("R2 sel_b untouched", {30'd0, sel_b}, 32'd0);
   endtask

   task automatic t_mw;
      apply(5'd1, 5'd12, 5'd30, 1'b1, 5'd12, 1'b1);
      chk("R3 sel_b", {30'd0, sel_b}, 32'd2);
      chk("R3 opnd_b", opnd_b, MWV);
      chk("R3 sel_a untouched", {30'd0, sel_a}, 32'd0);
   endtask

   task automatic t_both;
      apply(5'd8, 5'd8, 5'd8, 1'b1, 5'd8, 1'b1);
      chk("R4 sel_a", {30'd0, sel_a}, 32'd1);
      chk("R4 opnd_a", opnd_a, EMV);
      chk("R4 opnd_b", opnd_b, EMV);
   endtask

   task automatic t_wen_low;
      apply(5'd8, 5'd8, 5'd8, 1'b0, 5'd8, 1'b1);
      chk("R5 em off sel_a", {30'd0, sel_a}, 32'd2);
      chk("R5 em off opnd_a", opnd_a, MWV);
      apply(5'd8, 5'd8, 5'd8, 1'b0, 5'd8, 1'b0);
      chk("R5 both off sel_a", {30'd0, sel_a}, 32'd0);
      chk("R5 both off opnd_b", opnd_b, RFB);
   endtask

   task automatic t_zero;
      apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
      chk("R6 sel_a", {30'd0, sel_a}, 32'd0);
      chk("R6 opnd_a", opnd_a, RFA);
      chk("R6 opnd_b", opnd_b, RFB);
   endtask

   task automatic t_split;
      apply(5'd17, 5'd21, 5'd21, 1'b1, 5'd17, 1'b1);
      chk("R7 sel_a", {30'd0, sel_a}, 32'd2);
      chk("R7 sel_b", {30'd0, sel_b}, 32'd1);
      chk("R7 opnd_a", opnd_a, MWV);
      chk("R7 opnd_b", opnd_b, EMV);
   endtask

   task automatic t_decode;
      @(negedge clk);
      id_src_a = 5'd11; id_src_b = 5'd12; mw_dst = 5'd11; mw_wen = 1'b1;
      #2;
      chk("R8 hit", id_rd_a, MWV);
      chk("R8 miss", id_rd_b, IRB);
      @(negedge clk);
      mw_wen = 1'b0;
      #2;
      chk("R8 wen low", id_rd_a, IRA);
      @(negedge clk);
      id_src_a = 5'd0; mw_dst = 5'd0; mw_wen = 1'b1;
      #2;
      chk("R8 reg0", id_rd_a, IRA);
   endtask

   task automatic t_sweep;
      for (int r = 0; r < 32; r++) begin
         logic [1:0] ea;
         logic [1:0] eb;
         apply(r[4:0], r[4:0], r[4:0], 1'b1, 5'(r + 1), 1'b1);
         ea = (r == 0) ? 2'd0 : 2'd1;
         chk("R9 sweep em sel_a", {30'd0, sel_a}, {30'd0, ea});
         apply(r[4:0], 5'(r + 1), 5'(r + 2), 1'b1, r[4:0], 1'b1);
         eb = (r == 0) ? 2'd0 : 2'd2;
         chk("R9 sweep mw sel_a", {30'd0, sel_a}, {30'd0, eb});
         chk("R9 sweep no 11", {31'd0, sel_b == 2'b11}, 32'd0);
      end
   endtask

   initial begin : wdog
      #2000000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin
      ex_src_a = '0; ex_src_b = '0; em_dst = '0; mw_dst = '0;
      id_src_a = '0; id_src_b = '0;
      em_wen = 1'b0; mw_wen = 1'b0;
      ex_rf_a = RFA; ex_rf_b = RFB; em_val = EMV; mw_val = MWV;
      id_raw_a = IRA; id_raw_b = IRB;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      t_reset();
      t_no_match();
      t_em();
      t_mw();
      t_both();
      t_wen_low();
      t_zero();
      t_split();
      t_decode();
      t_sweep();
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

endmodule